// File: doc/BRIEF.md
# SD Host Data FIFO Packer

This block sits between a 32-bit register port used by software and a byte-wide data port facing an SD card engine. It holds a 16-word FIFO. During a read command it collects bytes from the card side into 32-bit words, filling the lowest byte first, and software pops them through the data register. During a write command software pushes words into the FIFO, and the block sends each one to the card side as four bytes, lowest byte first.

The transfer length is a byte counter. Writing the block-count register loads it with block count times the bytes-per-block value. When the counter is zero the block marks completion. It sets a data flag, puts a mode code into a debug register, and raises interrupt status bits that the configuration register enables. The debug register also shows the live FIFO fill level. At most one byte crosses the card port per clock, under a valid/ready handshake.

Register select `busAddr`: 0 data, 1 command, 2 config, 3 bytes-per-block, 4 block count, 5 status, 6 debug. Command bits: bit 0 read direction, bit 1 write command, bit 2 busy-wait. Config bits: 4 enables the completion interrupt, 8 enables the write-block interrupt, 10 enables the busy interrupt. Status bits: 0 data flag, 8 completion interrupt, 9 write-block interrupt, 10 busy interrupt. Only data, status and debug read back; the other selects read as zero.

Top module: `sd_fifo_packer`

## Requirements
- R1: After reset, status reads 0, debug reads 0x0000C60F, `irq` is 0, and a data read returns 0.
- R2: The FIFO is 16 words deep and first-in first-out. A data write pushes a word and a data read pops one. A push into a full FIFO is dropped, and a pop from an empty FIFO returns 0.
- R3: With the read direction selected, `cardRxReady` is high only while the counter is nonzero and the FIFO is not full. Accepted bytes fill a word from bits 7:0 upward, and each completed word is pushed.
- R4: When the counter reaches zero with 1 to 3 bytes gathered, that partial word is pushed, with its unfilled upper bytes zero.
- R5: With the write direction selected, a word is popped and sent as four bytes, low byte first, one per handshake. The counter drops by one per byte. When it reaches zero, any bytes left in the current word are discarded and `cardTxValid` stays low.
- R6: Writing the block-count register loads the counter with block count × bytes-per-block. Exactly that many bytes cross the card port.
- R7: Completion sets status bit 0 and debug bits 3:0 to 1. Completion happens on the last byte, or on a data access, config write or block-count write that leaves the counter at zero.
- R8: At completion, status bit 8 is set if config bit 4 is set. Bit 10 is set if the command has busy-wait and config bit 10 is set. Bit 9 is set if the command is a write and config bit 8 is set.
- R9: `irq` is the OR of status bits 10:8. Writing the status register clears each bit written as 1.
- R10: Debug bits 8:4 read the current FIFO fill level, 0 to 16.
- R11: A debug write whose bits 3:0 are 0xF stores 0 in those bits; other values are stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (pops on data select) |
| busAddr | input | 3 | Register select |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data, valid in the strobe cycle |
| cardRxData | input | 8 | Byte from card side (read direction) |
| cardRxValid | input | 1 | Card byte available |
| cardRxReady | output | 1 | Block accepts a card byte |
| cardTxData | output | 8 | Byte to card side (write direction) |
| cardTxValid | output | 1 | Block offers a byte |
| cardTxReady | input | 1 | Card side takes the byte |
| irq | output | 1 | Interrupt request |

## Verification
Read transfers use lengths that are and are not multiples of four. Each length is split across several blocks, so both packing and the trailing partial word are exercised. Card-side stalls vary, which separates per-byte acceptance from per-word pushing. A read longer than the FIFO shows that backpressure stops the card port. Write transfers end mid-word, which tells the leftover-byte discard apart from a spurious extra pop. Random command and config flag mixes separate the three interrupt gating paths, and a zero-length load shows completion without any byte moving.

// File: rtl/sdpk_pkg.sv
package sdpk_pkg;

  typedef enum logic [2:0] {
    REG_DATA   = 3'd0,
    REG_CMD    = 3'd1,
    REG_CFG    = 3'd2,
    REG_BYTES  = 3'd3,
    REG_BLOCKS = 3'd4,
    REG_STATUS = 3'd5,
    REG_DEBUG  = 3'd6,
    REG_NONE   = 3'd7
  } regSel_e;

  // command flag positions
  localparam int CMD_READ  = 0;
  localparam int CMD_WRITE = 1;
  localparam int CMD_BUSY  = 2;

  // config enable positions
  localparam int CFG_DONE_IE = 4;
  localparam int CFG_BLK_IE  = 8;
  localparam int CFG_BUSY_IE = 10;

  // status positions
  localparam int STS_DATA     = 0;
  localparam int STS_DONE_IRQ = 8;
  localparam int STS_BLK_IRQ  = 9;
  localparam int STS_BUSY_IRQ = 10;
  localparam int STS_W        = 11;

  localparam logic [31:0] DEBUG_RESET = 32'h0000_C60F;
  localparam logic [3:0]  DBG_DATA_MODE = 4'h1;

  typedef struct packed {
    logic rxTake;    // accept card byte into packing register
    logic pushPack;  // push packed word (with this cycle's byte)
    logic busPush;   // push software word
    logic busPop;    // pop for software read
    logic txLoad;    // pop head into unpacking register
    logic txShift;   // one byte handed to card
    logic txDrop;    // discard remaining unpacked bytes
  } dpCtl_t;

endpackage

// File: rtl/sdpk_datapath.sv
module sdpk_datapath
  import sdpk_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  dpCtl_t                         ctl,
  input  logic [31:0]                    busWrData,
  input  logic [7:0]                     cardRxData,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic                           full,
  output logic                           empty,
  output logic [31:0]                    headWord,
  output logic [1:0]                     packLane,
  output logic [2:0]                     txLeft,
  output logic [7:0]                     txByte
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [31:0]      packWord, packMerged, pushData, txWord;
  logic             pushEn, popEn, doPush, doPop;

  assign full     = (level == LVL_W'(DEPTH));
  assign empty    = (level == '0);
  assign headWord = mem[rdPtr];
  assign txByte   = txWord[7:0];

  assign packMerged = ctl.rxTake ? (packWord | (32'(cardRxData) << {packLane, 3'b000}))
                                 : packWord;
  assign pushEn   = ctl.pushPack | ctl.busPush;
  assign pushData = ctl.pushPack ? packMerged : busWrData;
  assign popEn    = ctl.busPop | ctl.txLoad;
  assign doPop    = popEn && !empty;
  assign doPush   = pushEn && (!full || doPop);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      level <= level + 1'b1;
      else if (doPop && !doPush) level <= level - 1'b1;
    end
  end

  // read-direction packing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      packWord <= '0;
      packLane <= '0;
    end else if (ctl.pushPack) begin
      packWord <= '0;
      packLane <= '0;
    end else if (ctl.rxTake) begin
      packWord <= packMerged;
      packLane <= packLane + 1'b1;
    end
  end

  // write-direction unpacking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txWord <= '0;
      txLeft <= '0;
    end else if (ctl.txDrop) begin
      txLeft <= '0;
    end else if (ctl.txLoad) begin
      txWord <= headWord;
      txLeft <= 3'd4;
    end else if (ctl.txShift) begin
      txWord <= txWord >> 8;
      txLeft <= txLeft - 1'b1;
    end
  end

  // R2: level moves by at most one word per cycle
  a_r2_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level) || level == $past(level) + 1'b1 ||
              level + 1'b1 == $past(level)));

  // R2: a push into a full FIFO without a pop leaves it full, never beyond
  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pushEn && !popEn) |=> (full && level == LVL_W'(DEPTH)));

  // R3: lanes fill in order between word pushes
  a_r3_lane_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rxTake && !ctl.pushPack) |=> (packLane == $past(packLane) + 1'b1));

endmodule

// File: rtl/sdpk_ctrl.sv
module sdpk_ctrl
  import sdpk_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int BYTES_W  = 16,
  parameter int BLOCKS_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        busWrEn,
  input  logic                        busRdEn,
  input  logic [2:0]                  busAddr,
  input  logic [31:0]                 busWrData,
  output logic [31:0]                 busRdData,
  input  logic                        cardRxValid,
  output logic                        cardRxReady,
  input  logic                        cardTxReady,
  output logic                        cardTxValid,
  output logic                        irq,
  input  logic [$clog2(DEPTH+1)-1:0]  level,
  input  logic                        full,
  input  logic                        empty,
  input  logic [31:0]                 headWord,
  input  logic [1:0]                  packLane,
  input  logic [2:0]                  txLeft,
  output dpCtl_t                      ctl
);

  localparam int CNT_W = BYTES_W + BLOCKS_W;
  localparam logic [22:0] DBG_HI_RESET = DEBUG_RESET[31:9];

  regSel_e            sel;
  logic [2:0]         cmdReg;
  logic               cfgDoneIe, cfgBlkIe, cfgBusyIe;
  logic               nxtDoneIe, nxtBlkIe, nxtBusyIe;
  logic [BYTES_W-1:0] bytesReg;
  logic [CNT_W-1:0]   count, nextCount;
  logic [STS_W-1:0]   status, setBits;
  logic [22:0]        dbgHi;
  logic [3:0]         dbgState;
  logic dataRd, dataWr, cmdWr, cfgWr, bytesWr, blocksWr, statusWr, debugWr;
  logic isRead, cntNz, lastCnt, byteStep, resume, doneEv;

  assign sel      = regSel_e'(busAddr);
  assign dataRd   = busRdEn && sel == REG_DATA;
  assign dataWr   = busWrEn && sel == REG_DATA;
  assign cmdWr    = busWrEn && sel == REG_CMD;
  assign cfgWr    = busWrEn && sel == REG_CFG;
  assign bytesWr  = busWrEn && sel == REG_BYTES;
  assign blocksWr = busWrEn && sel == REG_BLOCKS;
  assign statusWr = busWrEn && sel == REG_STATUS;
  assign debugWr  = busWrEn && sel == REG_DEBUG;

  assign isRead  = cmdReg[CMD_READ];
  assign cntNz   = count != '0;
  assign lastCnt = count == CNT_W'(1);

  // card handshakes
  assign cardRxReady = isRead && cntNz && !full;
  assign cardTxValid = !isRead && cntNz && (txLeft != '0);

  always_comb begin
    ctl          = '0;
    ctl.rxTake   = cardRxReady && cardRxValid;
    ctl.pushPack = ctl.rxTake && (packLane == 2'd3 || lastCnt);
    ctl.txShift  = cardTxValid && cardTxReady;
    ctl.txDrop   = ctl.txShift && lastCnt;
    ctl.busPop   = dataRd && !empty;
    ctl.txLoad   = !isRead && cntNz && (txLeft == '0) && !empty && !ctl.busPop;
    ctl.busPush  = dataWr && !ctl.pushPack && (!full || ctl.busPop || ctl.txLoad);
  end

  assign byteStep = ctl.rxTake | ctl.txShift;
  assign resume   = dataRd | dataWr | cfgWr | blocksWr;

  always_comb begin
    if (blocksWr)
      nextCount = CNT_W'(busWrData[BLOCKS_W-1:0]) * CNT_W'(bytesReg);
    else if (byteStep)
      nextCount = count - CNT_W'(1);
    else
      nextCount = count;
  end

  assign doneEv = (nextCount == '0) && ((byteStep && lastCnt) || resume);

  assign nxtDoneIe = cfgWr ? busWrData[CFG_DONE_IE] : cfgDoneIe;
  assign nxtBlkIe  = cfgWr ? busWrData[CFG_BLK_IE]  : cfgBlkIe;
  assign nxtBusyIe = cfgWr ? busWrData[CFG_BUSY_IE] : cfgBusyIe;

  always_comb begin
    setBits               = '0;
    setBits[STS_DATA]     = doneEv;
    setBits[STS_DONE_IRQ] = doneEv && nxtDoneIe;
    setBits[STS_BLK_IRQ]  = doneEv && cmdReg[CMD_WRITE] && nxtBlkIe;
    setBits[STS_BUSY_IRQ] = doneEv && cmdReg[CMD_BUSY] && nxtBusyIe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg    <= '0;
      cfgDoneIe <= 1'b0;
      cfgBlkIe  <= 1'b0;
      cfgBusyIe <= 1'b0;
      bytesReg  <= '0;
      count     <= '0;
      status    <= '0;
      dbgHi     <= DBG_HI_RESET;
      dbgState  <= DEBUG_RESET[3:0];
    end else begin
      if (cmdWr)   cmdReg   <= busWrData[2:0];
      if (bytesWr) bytesReg <= busWrData[BYTES_W-1:0];
      cfgDoneIe <= nxtDoneIe;
      cfgBlkIe  <= nxtBlkIe;
      cfgBusyIe <= nxtBusyIe;
      count     <= nextCount;
      status    <= (statusWr ? (status & ~busWrData[STS_W-1:0]) : status) | setBits;
      if (debugWr) begin
        dbgHi    <= busWrData[31:9];
        dbgState <= (busWrData[3:0] == 4'hF) ? 4'h0 : busWrData[3:0];
      end
      if (doneEv) dbgState <= DBG_DATA_MODE;
    end
  end

  assign irq = |status[STS_BUSY_IRQ:STS_DONE_IRQ];

  always_comb begin
    case (sel)
      REG_DATA:   busRdData = empty ? '0 : headWord;
      REG_STATUS: busRdData = 32'(status);
      REG_DEBUG:  busRdData = {dbgHi, 5'(level), dbgState};
      default:    busRdData = '0;
    endcase
  end

  // R6: counter only reloads on a block-count write, otherwise steps down by one at most
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !blocksWr |=> (count == $past(count) || count == $past(count) - CNT_W'(1)));

  // R7: data flag rising always comes with the data-mode debug code
  a_r7_done_marks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[STS_DATA]) |-> (dbgState == DBG_DATA_MODE));

  // R9: interrupt stays up until software clears status
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !statusWr) |=> irq);

endmodule

// File: rtl/sd_fifo_packer.sv
module sd_fifo_packer
  import sdpk_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int BYTES_W  = 16,
  parameter int BLOCKS_W = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic [7:0]  cardRxData,
  input  logic        cardRxValid,
  output logic        cardRxReady,
  output logic [7:0]  cardTxData,
  output logic        cardTxValid,
  input  logic        cardTxReady,
  output logic        irq
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  dpCtl_t            ctl;
  logic [LVL_W-1:0]  level;
  logic              full, empty;
  logic [31:0]       headWord;
  logic [1:0]        packLane;
  logic [2:0]        txLeft;

  sdpk_ctrl #(.DEPTH(DEPTH), .BYTES_W(BYTES_W), .BLOCKS_W(BLOCKS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .cardRxValid(cardRxValid), .cardRxReady(cardRxReady),
    .cardTxReady(cardTxReady), .cardTxValid(cardTxValid),
    .irq(irq), .level(level), .full(full), .empty(empty),
    .headWord(headWord), .packLane(packLane), .txLeft(txLeft), .ctl(ctl)
  );

  sdpk_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .busWrData(busWrData), .cardRxData(cardRxData),
    .level(level), .full(full), .empty(empty), .headWord(headWord),
    .packLane(packLane), .txLeft(txLeft), .txByte(cardTxData)
  );

  // R5: an offered byte is held until taken (no register write in between)
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cardTxValid && !cardTxReady && !busWrEn) |=> (cardTxValid && $stable(cardTxData)));

  // R3: card bytes are never accepted into a full FIFO
  a_r3_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cardRxReady |-> (level < LVL_W'(DEPTH)));

endmodule

// File: tb/test_sd_fifo_packer.sv
`timescale 1ns/100ps
module test_sd_fifo_packer;

  localparam logic [2:0] A_DATA = 3'd0, A_CMD = 3'd1, A_CFG = 3'd2, A_BYTES = 3'd3,
                         A_BLOCKS = 3'd4, A_STATUS = 3'd5, A_DEBUG = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0] cardRxData = '0;
  logic cardRxValid = 1'b0;
  logic cardRxReady;
  logic [7:0] cardTxData;
  logic cardTxValid;
  logic cardTxReady = 1'b0;
  logic irq;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  int rxStall = 0, txStall = 0;
  int rxIdx = 0;
  logic [7:0] rxSrc[$];
  logic [7:0] txSink[$];

  always #2.5 clk = ~clk;

  sd_fifo_packer i_sd_fifo_packer (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .cardRxData(cardRxData), .cardRxValid(cardRxValid), .cardRxReady(cardRxReady),
    .cardTxData(cardTxData), .cardTxValid(cardTxValid), .cardTxReady(cardTxReady),
    .irq(irq)
  );

  // card-side models: drive at falling edge, record handshakes before rising edge
  always @(negedge clk) begin
    if (rxIdx < rxSrc.size() && int'($urandom % 4) >= rxStall) begin
      cardRxValid = 1'b1;
      cardRxData  = rxSrc[rxIdx];
    end else begin
      cardRxValid = 1'b0;
    end
    cardTxReady = int'($urandom % 4) >= txStall;
    #1;
    if (cardRxValid && cardRxReady) rxIdx++;
    if (cardTxValid && cardTxReady) txSink.push_back(cardTxData);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  function automatic logic [31:0] expStatus(input logic [2:0] cmd, input logic [31:0] cfg);
    logic [31:0] s = 32'h1;
    if (cfg[4]) s[8] = 1'b1;
    if (cmd[1] && cfg[8]) s[9] = 1'b1;
    if (cmd[2] && cfg[10]) s[10] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] packAt(input int w, input int nBytes);
    logic [31:0] v = '0;
    for (int k = 0; k < 4; k++)
      if (w * 4 + k < nBytes) v[k*8 +: 8] = rxSrc[w * 4 + k];
    return v;
  endfunction

  task automatic doRead(input int bpb, input int blks, input logic [2:0] cmd,
                        input logic [31:0] cfg, input int stall);
    logic [31:0] d;
    int n = bpb * blks;
    int nWords = (n + 3) / 4;
    rxSrc.delete(); rxIdx = 0; rxStall = stall;
    for (int k = 0; k < n + 4; k++) rxSrc.push_back(8'($urandom));
    busWrite(A_CFG, cfg);
    busWrite(A_CMD, 32'(cmd));
    busWrite(A_BYTES, 32'(bpb));
    busWrite(A_STATUS, 32'h7FF);
    busWrite(A_BLOCKS, 32'(blks));
    for (int t = 0; t < 3000 && rxIdx < n; t++) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R6 bytes consumed", 32'(rxIdx), 32'(n));
    busRead(A_STATUS, d);
    check("R7/R8 read status", d, expStatus(cmd, cfg));
    check("R9 irq", 32'(irq), 32'(|expStatus(cmd, cfg)[10:8]));
    busRead(A_DEBUG, d);
    check("R10 level", 32'(d[8:4]), 32'(nWords));
    check("R7 debug mode", 32'(d[3:0]), 32'h1);
    for (int w = 0; w < nWords; w++) begin
      busRead(A_DATA, d);
      check((w == nWords - 1 && n % 4 != 0) ? "R4 partial word" : "R3 packed word",
            d, packAt(w, n));
    end
  endtask

  task automatic doWrite(input int nWords, input int nBytes, input logic [2:0] cmd,
                         input logic [31:0] cfg, input int stall);
    logic [31:0] words[$];
    logic [31:0] d;
    int used = (nBytes + 3) / 4;
    txSink.delete(); txStall = stall;
    busWrite(A_CMD, 32'(cmd));
    busWrite(A_CFG, cfg);
    for (int w = 0; w < nWords; w++) begin
      words.push_back($urandom);
      busWrite(A_DATA, words[w]);
    end
    busWrite(A_BYTES, 32'(nBytes));
    busWrite(A_STATUS, 32'h7FF);
    busWrite(A_BLOCKS, 32'h1);
    for (int t = 0; t < 3000 && txSink.size() < nBytes; t++) @(negedge clk);
    repeat (8) @(negedge clk);
    check("R5 byte count", 32'(txSink.size()), 32'(nBytes));
    for (int k = 0; k < nBytes && k < txSink.size(); k++)
      check("R5 byte order", 32'(txSink[k]), 32'(words[k / 4][(k % 4) * 8 +: 8]));
    busRead(A_STATUS, d);
    check("R7/R8 write status", d, expStatus(cmd, cfg));
    busRead(A_DEBUG, d);
    check("R5/R10 level after write", 32'(d[8:4]), 32'(nWords - used));
    for (int w = used; w < nWords; w++) begin
      busRead(A_DATA, d);
      check("R2 remaining order", d, words[w]);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] q[$];
    void'($urandom(32'd20240607));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    busRead(A_STATUS, d);  check("R1 status", d, 32'h0);
    busRead(A_DEBUG, d);   check("R1 debug", d, 32'h0000C60F);
    check("R1 irq", 32'(irq), 32'h0);
    busRead(A_DATA, d);    check("R1 empty data", d, 32'h0);

    // R2 fill beyond depth, drain beyond empty
    for (int w = 0; w < 18; w++) begin
      q.push_back($urandom);
      busWrite(A_DATA, q[w]);
    end
    busRead(A_DEBUG, d);   check("R10 full level", 32'(d[8:4]), 32'd16);
    for (int w = 0; w < 16; w++) begin
      busRead(A_DATA, d);  check("R2 fifo order", d, q[w]);
    end
    busRead(A_DATA, d);    check("R2 pop empty", d, 32'h0);

    // R11 debug write handling
    busWrite(A_DEBUG, 32'h0000123F);
    busRead(A_DEBUG, d);   check("R11 state F stored as 0", d, 32'h00001200);
    busWrite(A_DEBUG, 32'h00001205);
    busRead(A_DEBUG, d);   check("R11 state stored", 32'(d[3:0]), 32'h5);

    // R7 zero-length load completes with no byte moved
    busWrite(A_STATUS, 32'h7FF);
    busWrite(A_BYTES, 32'd8);
    busWrite(A_BLOCKS, 32'd0);
    busRead(A_STATUS, d);  check("R7 zero length", d, 32'h1);

    // directed read: 15 bytes in 3 blocks, stalls
    doRead(5, 3, 3'b001, 32'h10, 1);

    // R3 backpressure: 80 bytes into a 16-word FIFO
    rxSrc.delete(); rxIdx = 0; rxStall = 0;
    for (int k = 0; k < 84; k++) rxSrc.push_back(8'($urandom));
    busWrite(A_CFG, 32'h0);
    busWrite(A_CMD, 32'h1);
    busWrite(A_BYTES, 32'd4);
    busWrite(A_STATUS, 32'h7FF);
    busWrite(A_BLOCKS, 32'd20);
    repeat (120) @(negedge clk);
    #1 check("R3 ready low when full", 32'(cardRxReady), 32'h0);
    check("R3 consumed at full", 32'(rxIdx), 32'd64);
    busRead(A_STATUS, d);  check("R7 not done while counting", d, 32'h0);
    for (int w = 0; w < 16; w++) begin
      busRead(A_DATA, d);  check("R3 backpressure word", d, packAt(w, 80));
    end
    repeat (40) @(negedge clk);
    for (int w = 16; w < 20; w++) begin
      busRead(A_DATA, d);  check("R3 resumed word", d, packAt(w, 80));
    end
    busRead(A_STATUS, d);  check("R7 done after drain", d, 32'h1);

    // directed write: 10 bytes from 3 words, write+busy, both enables
    doWrite(3, 10, 3'b110, 32'h500, 1);
    check("R9 irq raised", 32'(irq), 32'h1);
    busWrite(A_STATUS, 32'h400);
    busRead(A_STATUS, d);  check("R9 w1c busy bit", d, 32'h201);
    check("R9 irq still up", 32'(irq), 32'h1);
    busWrite(A_STATUS, 32'h200);
    check("R9 irq cleared", 32'(irq), 32'h0);

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [31:0] cfg;
      logic [2:0] flags;
      cfg = {21'h0, 1'($urandom), 1'b0, 1'($urandom), 3'b0, 1'($urandom), 4'h0};
      flags = {1'($urandom), 1'($urandom), 1'b0};
      if (it % 2 == 0)
        doRead(1 + int'($urandom % 16), 1 + int'($urandom % 4), {flags[2], 1'b0, 1'b1},
               cfg, int'($urandom % 3));
      else begin
        int k = 1 + int'($urandom % 16);
        doWrite(k, 1 + int'($urandom % (4 * k)), flags, cfg, int'($urandom % 3));
      end
    end

    finish_run();
  end

endmodule